// File: doc/BRIEF.md
# Error and Mode Status Register with Set/Clear Commands

This block keeps the operating-mode bits and the sticky error flags of a synchronous serial port controller. It holds eight state bits: a run enable (clear means configuration mode, set means operational mode), a master-select bit, and six sticky error flags. The error flags are mode error, transmit overflow, receive overflow, abort, transmit underflow and receive underflow. Software never writes these bits directly. Instead it writes a 16-bit command word in which each bit has its own set strobe and its own clear strobe. Software reads the bits back through a read-only status word, which also shows the live busy indication of the shift engine.

The shift engine and the FIFOs report error events as one-cycle pulses. Each event except mode error is latched only when its enable bit in the control word is set. Mode error has no enable and is always latched. A latched event takes priority over a clear command issued in the same cycle, so no error can be lost. The error interrupt is raised whenever any error flag is set and the interrupt enable is high.

Top module: `errstat_csr`

## Requirements
- R1: After reset every state bit is 0, the status word is zero except the live busy bit 13, `run_mode` and `master_mode` are 0, and `err_irq` is 0.
- R2: The status word places the state bits as follows: run enable at bit 0, master select at bit 1, mode error at 7, transmit overflow at 8, receive overflow at 9, abort at 10, transmit underflow at 11, receive underflow at 12. Bit 13 follows `busy_in` in the same cycle. All other bits read 0.
- R3: Command bit 0 clears the run enable and bit 1 sets it. Bit 2 clears master select and bit 3 sets it. The result is visible one cycle after the write.
- R4: Command bit 4 clears receive underflow and bit 5 sets it. Bit 6 clears mode error and bit 7 sets it.
- R5: Command bits 8, 9, 10 and 11 clear transmit overflow, receive overflow, abort and transmit underflow, in that order. Bits 12 to 15 set the same four flags in the same order.
- R6: Writing the command 0x0F50 clears all six error flags in one write and leaves the run enable and master select unchanged.
- R7: When the set bit and the clear bit of the same state bit are both 1 in one write, that state bit keeps its value.
- R8: The event vector `err_evt` uses this order: bit 0 mode error, 1 transmit overflow, 2 receive overflow, 3 abort, 4 transmit underflow, 5 receive underflow. Mode error is always latched. Each of the other five is latched only when its enable in `ctl_word` is set, at bits 8, 9, 10, 11 and 12 respectively.
- R9: A latched event in the same cycle as a clear command for the same flag leaves the flag set.
- R10: `err_irq` is 1 exactly when `err_irq_en` is 1 and at least one of the six error flags is set.
- R11: While `cmd_we` is 0, the value on `cmd_wdata` has no effect on any state bit.
- R12: `run_mode` and `master_mode` always equal status bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 16 | Command word with set and clear strobes |
| ctl_word | input | 16 | Control word; bits 8 to 12 enable error latching |
| err_evt | input | 6 | One-cycle error event pulses from the shift engine and FIFOs |
| busy_in | input | 1 | Live busy indication from the shift engine |
| err_irq_en | input | 1 | Error interrupt enable |
| status | output | 16 | Read-only status word |
| run_mode | output | 1 | 1 = operational mode, 0 = configuration mode |
| master_mode | output | 1 | Master-select state |
| err_irq | output | 1 | Error interrupt |

## Verification
Any wrong internal state appears at the ports on the very next clock edge, because every state bit drives the status word directly. A swapped command bit, a dropped enable gate, or clear taking priority over an event each produce a wrong status bit one cycle after the stimulus. A wrong flag also shows on `err_irq` in that same cycle. The bench sweeps every event pattern against every enable pattern together with a simultaneous clear-all write. It then drives a long stream of pseudo-random commands through an arithmetic model, so every bit position and every priority case is compared at that first cycle.

// File: rtl/errstat_pkg.sv
package errstat_pkg;

    localparam int unsigned CMD_W   = 16;
    localparam int unsigned STAT_W  = 16;
    localparam int unsigned N_FLAG  = 8;
    localparam int unsigned N_EVT   = 6;
    localparam int unsigned BUSY_POS = 13;

    // flag index: 0 run enable, 1 master, 2 mode err, 3 tx ovf,
    // 4 rx ovf, 5 abort, 6 tx udf, 7 rx udf
    typedef logic [N_FLAG-1:0] flag_vec_t;

    typedef struct packed {
        flag_vec_t flags;
    } csr_state_t;

    function automatic int unsigned stat_pos(int unsigned idx);
        case (idx)
            0:       return 0;
            1:       return 1;
            2:       return 7;
            3:       return 8;
            4:       return 9;
            5:       return 10;
            6:       return 11;
            default: return 12;
        endcase
    endfunction

    function automatic int unsigned clr_pos(int unsigned idx);
        case (idx)
            0:       return 0;
            1:       return 2;
            2:       return 6;
            3:       return 8;
            4:       return 9;
            5:       return 10;
            6:       return 11;
            default: return 4;
        endcase
    endfunction

    function automatic int unsigned set_pos(int unsigned idx);
        case (idx)
            0:       return 1;
            1:       return 3;
            2:       return 7;
            3:       return 12;
            4:       return 13;
            5:       return 14;
            6:       return 15;
            default: return 5;
        endcase
    endfunction

    // control-word enable position for event index (0 = always on)
    function automatic int unsigned gate_pos(int unsigned ev);
        return 7 + ev;
    endfunction

endpackage

// File: rtl/errstat_decode.sv
module errstat_decode
    import errstat_pkg::*;
(
    input  logic             we,
    input  logic [CMD_W-1:0] wdata,
    output flag_vec_t        set_v,
    output flag_vec_t        clr_v
);
    for (genvar i = 0; i < N_FLAG; i++) begin : g_dec
        assign set_v[i] = we & wdata[set_pos(i)];
        assign clr_v[i] = we & wdata[clr_pos(i)];
    end
endmodule

// File: rtl/errstat_evgate.sv
module errstat_evgate
    import errstat_pkg::*;
(
    input  logic [N_EVT-1:0] evt,
    input  logic [CMD_W-1:0] ctl,
    output flag_vec_t        hit_v
);
    localparam int unsigned FIRST_ERR = N_FLAG - N_EVT;

    for (genvar i = 0; i < FIRST_ERR; i++) begin : g_nohit
        assign hit_v[i] = 1'b0;
    end
    for (genvar e = 0; e < N_EVT; e++) begin : g_ev
        if (e == 0) begin : g_always
            assign hit_v[FIRST_ERR + e] = evt[e];
        end else begin : g_gated
            assign hit_v[FIRST_ERR + e] = evt[e] & ctl[gate_pos(e)];
        end
    end
endmodule

// File: rtl/errstat_flag_next.sv
module errstat_flag_next (
    input  logic cur,
    input  logic set_s,
    input  logic clr_s,
    input  logic hit,
    output logic nxt
);
    always_comb begin
        nxt = cur;
        if (hit) begin
            nxt = 1'b1;
        end else if (set_s && !clr_s) begin
            nxt = 1'b1;
        end else if (clr_s && !set_s) begin
            nxt = 1'b0;
        end
    end
endmodule

// File: rtl/errstat_csr.sv
module errstat_csr
    import errstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_wdata,
    input  logic [CMD_W-1:0]  ctl_word,
    input  logic [N_EVT-1:0]  err_evt,
    input  logic              busy_in,
    input  logic              err_irq_en,
    output logic [STAT_W-1:0] status,
    output logic              run_mode,
    output logic              master_mode,
    output logic              err_irq
);
    localparam int unsigned FIRST_ERR = N_FLAG - N_EVT;

    csr_state_t s_d, s_q;
    flag_vec_t  set_v, clr_v, hit_v, nxt_v;

    errstat_decode u_decode (
        .we    (cmd_we),
        .wdata (cmd_wdata),
        .set_v (set_v),
        .clr_v (clr_v)
    );

    errstat_evgate u_evgate (
        .evt   (err_evt),
        .ctl   (ctl_word),
        .hit_v (hit_v)
    );

    for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
        errstat_flag_next u_next (
            .cur   (s_q.flags[i]),
            .set_s (set_v[i]),
            .clr_s (clr_v[i]),
            .hit   (hit_v[i]),
            .nxt   (nxt_v[i])
        );
    end

    always_comb begin
        s_d       = s_q;
        s_d.flags = nxt_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        status           = '0;
        for (int unsigned i = 0; i < N_FLAG; i++) begin
            status[stat_pos(i)] = s_q.flags[i];
        end
        status[BUSY_POS] = busy_in;
    end

    assign run_mode    = s_q.flags[0];
    assign master_mode = s_q.flags[1];
    assign err_irq     = err_irq_en & (|s_q.flags[N_FLAG-1:FIRST_ERR]);

endmodule

// File: rtl/errstat_csr_chk.sv
module errstat_csr_chk
    import errstat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_we,
    input logic [CMD_W-1:0]  cmd_wdata,
    input logic [CMD_W-1:0]  ctl_word,
    input logic [N_EVT-1:0]  err_evt,
    input logic              err_irq_en,
    input logic [STAT_W-1:0] status,
    input logic              run_mode,
    input logic              err_irq
);
    AST_RUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_wdata[1] && !cmd_wdata[0]) |=> status[0]); // R3
    AST_RUN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_wdata[0] && !cmd_wdata[1]) |=> !run_mode); // R3
    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_wdata[2] && cmd_wdata[3]) |=> $stable(status[1])); // R7
    AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_wdata == 16'h0F50 && err_evt == '0) |=> (status[12:7] == '0)); // R6
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt[1] && ctl_word[8]) |=> status[8]); // R9
    AST_EVT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_we && !ctl_word[9]) |=> $stable(status[9])); // R8
    AST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_we && err_evt == '0) |=> $stable(status[12:0])); // R11
    AST_IRQ_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq == (err_irq_en && (|status[12:7]))); // R10
endmodule

bind errstat_csr errstat_csr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (cmd_we),
    .cmd_wdata  (cmd_wdata),
    .ctl_word   (ctl_word),
    .err_evt    (err_evt),
    .err_irq_en (err_irq_en),
    .status     (status),
    .run_mode   (run_mode),
    .err_irq    (err_irq)
);

// File: tb/errstat_csr_bench.sv
module errstat_csr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic [15:0] ctl_word = '0;
    logic [5:0]  err_evt = '0;
    logic        busy_in = 1'b0;
    logic        err_irq_en = 1'b0;
    logic [15:0] status;
    logic        run_mode, master_mode, err_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model state as status-word image (bits 0,1,7..12)
    logic [15:0] m_st = '0;

    always #2 clk = ~clk;

    errstat_csr u_errstat_csr (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .ctl_word(ctl_word), .err_evt(err_evt), .busy_in(busy_in),
        .err_irq_en(err_irq_en), .status(status), .run_mode(run_mode),
        .master_mode(master_mode), .err_irq(err_irq)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // status bit of the flag set/cleared by command bit b
    function automatic int target(int b);
        if (b < 4) return b / 2;           // run, master
        if (b < 6) return 12;              // rx udf
        if (b < 8) return 7;               // mode err
        if (b < 12) return b;              // clears 8..11
        return b - 4;                      // sets 12..15 -> 8..11
    endfunction

    function automatic bit is_set_bit(int b);
        if (b < 8) return (b % 2) == 1;
        return b >= 12;
    endfunction

    function automatic logic [15:0] model_next(logic [15:0] cur, logic we,
            logic [15:0] cmd, logic [5:0] ev, logic [15:0] ctl);
        logic [15:0] s = '0, c = '0, h = '0, n;
        if (we) begin
            for (int b = 0; b < 16; b++) begin
                if (cmd[b]) begin
                    if (is_set_bit(b)) s[target(b)] = 1'b1;
                    else               c[target(b)] = 1'b1;
                end
            end
        end
        h[7] = ev[0];
        for (int e = 1; e < 6; e++) h[7+e] = ev[e] & ctl[7+e];
        n = cur;
        for (int k = 0; k < 16; k++) begin
            if (h[k])               n[k] = 1'b1;
            else if (s[k] && !c[k]) n[k] = 1'b1;
            else if (c[k] && !s[k]) n[k] = 1'b0;
        end
        return n;
    endfunction

    task automatic step(input logic we, input logic [15:0] cmd, input logic [5:0] ev,
                        input logic [15:0] ctl, input logic bz, input logic ien,
                        input string req);
        logic [15:0] exp;
        logic        exp_irq;
        cmd_we = we; cmd_wdata = cmd; err_evt = ev; ctl_word = ctl;
        busy_in = bz; err_irq_en = ien;
        @(posedge clk);
        m_st = model_next(m_st, we, cmd, ev, ctl);
        @(negedge clk);
        exp = m_st | (16'(bz) << 13);
        chk(status == exp, req, status, exp);
        exp_irq = ien & (|m_st[12:7]);
        chk(err_irq == exp_irq, "R10", 16'(err_irq), 16'(exp_irq));
        chk({master_mode, run_mode} == m_st[1:0], "R12",
            16'({master_mode, run_mode}), 16'(m_st[1:0]));
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        // R1: reset state
        busy_in = 1'b1;
        #1;
        chk(status == 16'h2000, "R1", status, 16'h2000);
        chk(err_irq == 1'b0 && run_mode == 1'b0 && master_mode == 1'b0, "R1",
            16'({err_irq, master_mode, run_mode}), 16'h0);
        busy_in = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status == 16'h0000, "R1", status, 16'h0000);

        // R3: run and master
        step(1, 16'h0002, '0, '0, 0, 1, "R3");
        step(1, 16'h0008, '0, '0, 1, 1, "R3");
        step(1, 16'h0001, '0, '0, 0, 1, "R3");
        // every single command bit: set then clear and both (R3 R4 R5 R7)
        for (int b = 0; b < 16; b++) begin
            step(1, 16'(1) << b, '0, '0, 0, 1, "R4_R5_single");
            step(1, 16'hFFFF, '0, '0, 0, 1, "R7");
            step(1, 16'(1) << b, '0, '0, 1, 0, "R4_R5_single");
        end
        // R11: writes ignored without strobe
        step(1, 16'hF0AA, '0, '0, 0, 1, "R5");
        step(0, 16'h0F55, '0, '0, 0, 1, "R11");
        step(0, 16'hFFFF, '0, '0, 1, 1, "R11");
        // R6: clear-all keeps run and master
        step(1, 16'h0F50, '0, '0, 0, 1, "R6");
        chk(status[1:0] == 2'b11, "R6", 16'(status[1:0]), 16'h3);

        // R8 R9: every event pattern against every enable pattern with clear-all
        for (int en = 0; en < 32; en++) begin
            for (int ev = 0; ev < 64; ev++) begin
                step(1, 16'h0F50, 6'(ev), 16'(en) << 8, 1'(ev), 1'(en), "R8_R9");
            end
        end

        // R2 R10: pseudo-random command stream
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr ^ 16'(i * 16'h9E37), 6'((lfsr[5:0] & lfsr[11:6]) & 6'(i % 3 == 0 ? 63 : 0)),
                 {lfsr[7:0], lfsr[15:8]}, lfsr[3], lfsr[9], "R2");
        end

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule